// File: doc/BRIEF.md
# Compressed-Row Sparse Matrix-Vector Multiplier

This block computes y = A·x, where A is a sparse matrix in compressed-row form. It reads five external single-port memories, each with one cycle of read latency. The first holds the row boundaries. The second and third hold the column index and the coefficient of every nonzero, and share one address. The fourth holds the dense vector x, and the fifth receives y. A one-cycle `start_i` pulse launches a pass over all rows. A one-cycle `done_o` pulse reports that the last row result has been written.

Each row is walked in fixed-size groups of `S` nonzero slots, one slot per cycle. The column index read feeds the x address directly, so x is fetched one cycle after the index. The coefficient is delayed by one cycle to line up with it. Each group's products are gathered into a partial sum, and that partial sum is added to the row total once, when the group's last slot retires. Slots that fall past the row's end still take their cycle but add nothing. All arithmetic is signed two's complement, with an accumulator sized so it cannot overflow.

Top module: `spmv_engine`

## Requirements
- R1: After a pass, y[i] equals the exact signed sum over k in [row_ptr[i], row_ptr[i+1]) of coef[k]·x[col[k]], written at full accumulator width.
- R2: A row whose end pointer is not greater than its start pointer writes y[i] = 0 and spends no group cycles.
- R3: With g_i = ceil(n_i/S) groups for a row of n_i nonzeros, `done_o` rises exactly 2 + Σ c_i clock edges after the edge that samples `start_i`. Here c_i = 3 for an empty row and c_i = 6 + S·g_i otherwise, so every group lasts exactly S cycles.
- R4: Group slots at or beyond a row's end contribute nothing, whatever data the memories hold at the addresses involved.
- R5: `done_o` is high for exactly one cycle per pass, and in the cycle right after the write of y[NUM_ROWS-1].
- R6: Each pass writes every y address exactly once, in ascending order starting from 0, with `y_we_o` high for one cycle per write.
- R7: While `rst_ni` is low, and after its release until a start, `done_o` and `y_we_o` are low.
- R8: Extreme operands (coefficient and x both at the most negative value, or mixed signs at the full range) accumulate without wrap.
- R9: A `start_i` pulse that arrives while a pass is running is ignored. It changes neither the results nor the pass length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a pass (taken only when idle) |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| rp_addr_o | output | RPAW | Row-boundary memory address |
| rp_rdata_i | input | PW | Row-boundary read data, one cycle after the address |
| nz_addr_o | output | AW | Shared address of the column-index and coefficient memories |
| col_rdata_i | input | XAW | Column index read data |
| val_rdata_i | input | DW | Coefficient read data, signed |
| x_addr_o | output | XAW | Dense vector address |
| x_rdata_i | input | DW | Dense vector read data, signed |
| y_we_o | output | 1 | Result write strobe |
| y_addr_o | output | YAW | Result row address |
| y_wdata_o | output | ACC_W | Signed row result |

## Verification
The bench keeps the default build: NUM_ROWS = 6, NNZ = 40, VEC_LEN = 16, DW = 16 and S = 7. With a group of seven, row lengths of 0, 1, 6, 7, 8, 13, 14 and 20 give exactly full groups, one slot over, one slot short, and several groups per row. Tail masking and the per-group cycle cost are therefore both visible in the results and in the pass length. A 16-bit operand width lets the extreme-value run drive the 38-bit accumulator past the 32-bit range, which a truncating datapath would visibly wrap.

// File: rtl/spmv_pkg.sv
package spmv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_BASE, ST_PREQ, ST_PRSP,
    ST_GROUP, ST_DRAIN, ST_WRITE, ST_FIN
  } spmv_state_e;
endpackage

// File: rtl/spmv_ctrl.sv
module spmv_ctrl import spmv_pkg::*; #(
  parameter int NUM_ROWS = 6,
  parameter int NNZ      = 40,
  parameter int S        = 7,
  localparam int PW   = $clog2(NNZ + 1),
  localparam int AW   = $clog2(NNZ),
  localparam int RPAW = $clog2(NUM_ROWS + 1),
  localparam int YAW  = $clog2(NUM_ROWS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            busy_i,
  output logic [RPAW-1:0] rp_addr_o,
  input  logic [PW-1:0]   rp_rdata_i,
  output logic [AW-1:0]   nz_addr_o,
  output logic            issue_act_o,
  output logic            issue_vld_o,
  output logic            issue_last_o,
  output logic            acc_clr_o,
  output logic            y_we_o,
  output logic [YAW-1:0]  y_addr_o,
  output logic            done_o
);
  localparam int KW = $clog2(NNZ + S + 1);
  localparam int SW = (S > 1) ? $clog2(S) : 1;

  spmv_state_e      state_q;
  logic [KW-1:0]    k_q, end_q, slot_idx, k_nxt, rp_ext;
  logic [SW-1:0]    slot_q;
  logic [YAW-1:0]   row_q;

  assign slot_idx = k_q + KW'(slot_q);
  assign k_nxt    = k_q + KW'(S);
  assign rp_ext   = KW'(rp_rdata_i);

  always_comb begin
    issue_act_o  = (state_q == ST_GROUP);
    issue_vld_o  = issue_act_o && (slot_idx < end_q);
    issue_last_o = issue_act_o && (slot_q == SW'(S - 1));
    nz_addr_o    = issue_vld_o ? AW'(slot_idx) : '0;  // masked slots park on 0
    rp_addr_o    = (state_q == ST_PREQ) ? RPAW'(row_q) + RPAW'(1) : '0;
    acc_clr_o    = (state_q == ST_PRSP);
    y_we_o       = (state_q == ST_WRITE);
    y_addr_o     = row_q;
    done_o       = (state_q == ST_FIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      end_q   <= '0;
      slot_q  <= '0;
      row_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_START;
        ST_START: state_q <= ST_BASE;
        ST_BASE: begin
          end_q   <= rp_ext;
          row_q   <= '0;
          state_q <= ST_PREQ;
        end
        ST_PREQ:  state_q <= ST_PRSP;
        ST_PRSP: begin
          k_q     <= end_q;
          end_q   <= rp_ext;
          slot_q  <= '0;
          state_q <= (rp_ext <= end_q) ? ST_WRITE : ST_GROUP;
        end
        ST_GROUP: begin
          if (slot_q == SW'(S - 1)) begin
            slot_q <= '0;
            k_q    <= k_nxt;
            if (k_nxt >= end_q) state_q <= ST_DRAIN;
          end else begin
            slot_q <= slot_q + SW'(1);
          end
        end
        ST_DRAIN: if (!busy_i) state_q <= ST_WRITE;
        ST_WRITE: begin
          if (row_q == YAW'(NUM_ROWS - 1)) begin
            state_q <= ST_FIN;
          end else begin
            row_q   <= row_q + YAW'(1);
            state_q <= ST_PREQ;
          end
        end
        ST_FIN:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spmv_mac.sv
module spmv_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 38
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    act_i,
  input  logic                    vld_i,
  input  logic                    last_i,
  input  logic signed [DW-1:0]    val_rdata_i,
  input  logic signed [DW-1:0]    x_rdata_i,
  output logic                    busy_o,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int PRW = 2 * DW;

  logic                    act1_q, vld1_q, last1_q;
  logic                    act2_q, vld2_q, last2_q;
  logic signed [DW-1:0]    val2_q;
  logic signed [PRW-1:0]   prod;
  logic signed [ACC_W-1:0] prod_ext, part_q, acc_q;

  always_comb begin
    prod     = vld2_q ? PRW'(val2_q) * PRW'(x_rdata_i) : '0;
    prod_ext = {{(ACC_W - PRW){prod[PRW-1]}}, prod};
  end

  // stage 1: index and coefficient returned; stage 2: x returned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {act1_q, vld1_q, last1_q} <= '0;
      {act2_q, vld2_q, last2_q} <= '0;
      val2_q <= '0;
      part_q <= '0;
      acc_q  <= '0;
    end else begin
      {act1_q, vld1_q, last1_q} <= {act_i, vld_i, last_i};
      {act2_q, vld2_q, last2_q} <= {act1_q, vld1_q, last1_q};
      val2_q <= val_rdata_i;
      if (clr_i) begin
        part_q <= '0;
        acc_q  <= '0;
      end else if (act2_q) begin
        if (last2_q) begin
          acc_q  <= acc_q + part_q + prod_ext;
          part_q <= '0;
        end else begin
          part_q <= part_q + prod_ext;
        end
      end
    end
  end

  assign busy_o = act1_q | act2_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/spmv_engine.sv
module spmv_engine #(
  parameter int NUM_ROWS = 6,
  parameter int NNZ      = 40,
  parameter int VEC_LEN  = 16,
  parameter int DW       = 16,
  parameter int S        = 7,
  localparam int PW    = $clog2(NNZ + 1),
  localparam int AW    = $clog2(NNZ),
  localparam int RPAW  = $clog2(NUM_ROWS + 1),
  localparam int YAW   = $clog2(NUM_ROWS),
  localparam int XAW   = $clog2(VEC_LEN),
  localparam int ACC_W = 2 * DW + $clog2(NNZ + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  output logic                    done_o,
  output logic [RPAW-1:0]         rp_addr_o,
  input  logic [PW-1:0]           rp_rdata_i,
  output logic [AW-1:0]           nz_addr_o,
  input  logic [XAW-1:0]          col_rdata_i,
  input  logic signed [DW-1:0]    val_rdata_i,
  output logic [XAW-1:0]          x_addr_o,
  input  logic signed [DW-1:0]    x_rdata_i,
  output logic                    y_we_o,
  output logic [YAW-1:0]          y_addr_o,
  output logic signed [ACC_W-1:0] y_wdata_o
);
  logic busy, issue_act, issue_vld, issue_last, acc_clr;

  spmv_ctrl #(.NUM_ROWS(NUM_ROWS), .NNZ(NNZ), .S(S)) ctrl_i (
    .clk_i, .rst_ni, .start_i,
    .busy_i      (busy),
    .rp_addr_o, .rp_rdata_i, .nz_addr_o,
    .issue_act_o (issue_act),
    .issue_vld_o (issue_vld),
    .issue_last_o(issue_last),
    .acc_clr_o   (acc_clr),
    .y_we_o, .y_addr_o, .done_o
  );

  // column index returned this cycle becomes the x address
  assign x_addr_o = col_rdata_i;

  spmv_mac #(.DW(DW), .ACC_W(ACC_W)) mac_i (
    .clk_i, .rst_ni,
    .clr_i       (acc_clr),
    .act_i       (issue_act),
    .vld_i       (issue_vld),
    .last_i      (issue_last),
    .val_rdata_i,
    .x_rdata_i,
    .busy_o      (busy),
    .acc_o       (y_wdata_o)
  );
endmodule

// File: rtl/spmv_engine_chk.sv
module spmv_engine_chk #(
  parameter int NUM_ROWS = 6,
  parameter int S        = 7,
  parameter int YAW      = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           done_o,
  input logic           y_we_o,
  input logic [YAW-1:0] y_addr_o,
  input logic           issue_act,
  input logic           issue_last
);
  localparam int RW = $clog2(S + 1);
  logic [RW-1:0]  run_q;
  logic [YAW-1:0] next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      next_q <= '0;
    end else begin
      if (issue_last)     run_q <= '0;
      else if (issue_act) run_q <= run_q + RW'(1);
      if (y_we_o) next_q <= (y_addr_o == YAW'(NUM_ROWS - 1)) ? '0 : y_addr_o + YAW'(1);
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(y_we_o) && ($past(y_addr_o) == YAW'(NUM_ROWS - 1)));
  // R3
  group_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_last |-> (run_q == RW'(S - 1)));
  // R6
  y_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_we_o |-> (y_addr_o == next_q));
  // R6
  y_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_we_o |-> (y_addr_o < YAW'(NUM_ROWS)));
  // R6
  y_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_we_o |=> !y_we_o);
  // R7
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !done_o && !y_we_o);
endmodule

bind spmv_engine spmv_engine_chk #(.NUM_ROWS(NUM_ROWS), .S(S), .YAW(YAW)) chk_i (
  .clk_i, .rst_ni, .done_o, .y_we_o, .y_addr_o,
  .issue_act (issue_act),
  .issue_last(issue_last)
);

// File: tb/spmv_engine_tb_top.sv
module spmv_engine_tb_top;
  localparam int NUM_ROWS = 6;
  localparam int NNZ      = 40;
  localparam int VEC_LEN  = 16;
  localparam int DW       = 16;
  localparam int S        = 7;
  localparam int PW    = $clog2(NNZ + 1);
  localparam int AW    = $clog2(NNZ);
  localparam int RPAW  = $clog2(NUM_ROWS + 1);
  localparam int YAW   = $clog2(NUM_ROWS);
  localparam int XAW   = $clog2(VEC_LEN);
  localparam int ACC_W = 2 * DW + $clog2(NNZ + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, y_we;
  logic [RPAW-1:0] rp_addr;
  logic [PW-1:0]   rp_rdata;
  logic [AW-1:0]   nz_addr;
  logic [XAW-1:0]  col_rdata, x_addr;
  logic signed [DW-1:0] val_rdata, x_rdata;
  logic [YAW-1:0]  y_addr;
  logic signed [ACC_W-1:0] y_wdata;

  always #4 clk = ~clk;  // 125 MHz

  logic [PW-1:0]        rp_mem  [NUM_ROWS+1];
  logic [XAW-1:0]       col_mem [NNZ];
  logic signed [DW-1:0] val_mem [NNZ];
  logic signed [DW-1:0] x_mem   [VEC_LEN];
  longint               y_got   [NUM_ROWS];
  int                   row_len [NUM_ROWS];

  always_ff @(posedge clk) begin
    rp_rdata  <= rp_mem[rp_addr];
    col_rdata <= col_mem[nz_addr];
    val_rdata <= val_mem[nz_addr];
    x_rdata   <= x_mem[x_addr];
  end

  spmv_engine #(.NUM_ROWS(NUM_ROWS), .NNZ(NNZ), .VEC_LEN(VEC_LEN), .DW(DW), .S(S)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done),
    .rp_addr_o(rp_addr), .rp_rdata_i(rp_rdata), .nz_addr_o(nz_addr),
    .col_rdata_i(col_rdata), .val_rdata_i(val_rdata),
    .x_addr_o(x_addr), .x_rdata_i(x_rdata),
    .y_we_o(y_we), .y_addr_o(y_addr), .y_wdata_o(y_wdata)
  );

  int checks = 0, fails = 0;
  int wr_cnt = 0, wr_bad = 0, done_cnt = 0, next_row = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && y_we) begin
      y_got[y_addr] = longint'(y_wdata);
      if (int'(y_addr) != next_row) wr_bad++;
      next_row = int'(y_addr) + 1;
      wr_cnt++;
    end
    if (rst_n && done) done_cnt++;
  end

  function automatic longint exp_y(input int r);
    longint s = 0;
    for (int k = int'(rp_mem[r]); k < int'(rp_mem[r+1]); k++)
      s += longint'(val_mem[k]) * longint'(x_mem[col_mem[k]]);
    return s;
  endfunction

  function automatic int exp_lat();
    int l = 2;
    for (int r = 0; r < NUM_ROWS; r++) begin
      int n = int'(rp_mem[r+1]) - int'(rp_mem[r]);
      l += (n > 0) ? 6 + S * ((n + S - 1) / S) : 3;
    end
    return l;
  endfunction

  task automatic build(input bit extreme);
    int p = 0;
    for (int k = 0; k < NNZ; k++) begin
      col_mem[k] = XAW'($urandom_range(0, VEC_LEN - 1));
      val_mem[k] = extreme ? ((k % 3 == 0) ? 16'sh7fff : 16'sh8000) : DW'($urandom);
    end
    for (int i = 0; i < VEC_LEN; i++)
      x_mem[i] = extreme ? 16'sh8000 : DW'($urandom);
    rp_mem[0] = '0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      p += row_len[r];
      rp_mem[r+1] = PW'(p);
    end
  endtask

  task automatic run(input string tag, input bit repulse);
    int cnt = 0;
    longint lat;
    wr_cnt = 0; wr_bad = 0; done_cnt = 0; next_row = 0;
    for (int r = 0; r < NUM_ROWS; r++) y_got[r] = 64'h5a5a;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      start = repulse && (cnt == 10);
    end
    start = 1'b0;
    lat = exp_lat();
    chk(cnt == lat, {"R3 pass length ", tag}, cnt, lat);
    if (repulse) chk(cnt == lat, {"R9 late start ignored ", tag}, cnt, lat);
    for (int r = 0; r < NUM_ROWS; r++) begin
      longint e = exp_y(r);
      chk(y_got[r] == e, $sformatf("R1 R4 row %0d %s", r, tag), y_got[r], e);
      if (row_len[r] == 0) chk(y_got[r] == 0, {"R2 empty row ", tag}, y_got[r], 0);
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {"R5 done pulses ", tag}, done_cnt, 1);
    chk(wr_cnt == NUM_ROWS && wr_bad == 0, {"R6 write count/order ", tag}, wr_cnt, NUM_ROWS);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r <= NUM_ROWS; r++) rp_mem[r] = '0;
    for (int k = 0; k < NNZ; k++) begin col_mem[k] = '0; val_mem[k] = '0; end
    for (int i = 0; i < VEC_LEN; i++) x_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!done && !y_we, "R7 in reset", {done, y_we}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && !y_we, "R7 idle after reset", {done, y_we}, 0);

    row_len = '{0, 7, 8, 1, 14, 6};
    build(1'b0); run("directed group edges", 1'b0);
    row_len = '{0, 0, 13, 0, 20, 7};
    build(1'b1); run("R8 extreme operands", 1'b0);
    row_len = '{0, 0, 0, 0, 0, 0};
    build(1'b0); run("all empty", 1'b0);
    row_len = '{2, 9, 0, 7, 5, 15};
    build(1'b0); run("R9 repulse", 1'b1);
    for (int t = 0; t < 6; t++) begin
      int left = NNZ;
      for (int r = 0; r < NUM_ROWS; r++) begin
        row_len[r] = $urandom_range(0, (left < 12) ? left : 12);
        left -= row_len[r];
      end
      build(1'b0); run($sformatf("random %0d", t), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule